// File: doc/BRIEF.md
# Thirty-Two-Bit Arithmetic-Logic Unit with Zero Flag

This block is a purely combinational arithmetic-logic unit for a simple processor datapath. Two 32-bit operands and a 4-bit operation selector go in. The selected result comes out together with a one-bit flag that is high whenever that result is all zeros. The surrounding datapath uses the flag for branch decisions: it issues a subtraction and tests the flag to learn whether two registers hold equal values.

The unit offers six operations: bitwise AND, bitwise OR, bitwise NOR, wrapping addition, wrapping subtraction and a signed set-less-than. Addition, subtraction and the comparison share one adder. The comparison and the subtraction drive that adder in its inverting mode, and the comparison takes its answer from the sign of the difference corrected by the overflow condition. Selector values that name no operation produce an all-zero result.

Top module: `arith_logic_unit`

## Requirements
- R1: Selector 4'b0000 returns the bitwise AND of the two operands.
- R2: Selector 4'b0001 returns the bitwise OR of the two operands.
- R3: Selector 4'b0010 returns a + b modulo 2^32; a carry out of bit 31 is discarded and nothing signals it.
- R4: Selector 4'b0110 returns a - b modulo 2^32; a borrow or a signed overflow is discarded and nothing signals it.
- R5: Selector 4'b0111 treats both operands as signed two's-complement numbers. It returns 1 in bit 0 when a < b and 0 otherwise, and bits 31 to 1 are always zero.
- R6: Selector 4'b1100 returns the bitwise NOR of the two operands.
- R7: The zero output is 1 exactly when the 32-bit result equals zero, whatever the selector. In particular, with selector 4'b0110 it is 1 exactly when the operands are equal.
- R8: Every selector value other than the six above returns an all-zero result, so the zero output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation selector |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The checks assume that the operands and the selector are settled, known values whenever they are evaluated. They skip any evaluation in which the selector carries unknown bits. The bench therefore drives every input from procedural code with fully defined values and changes the inputs only at one point in each clock period. It samples half a period later, so every check sees a settled, defined selector and a settled result.

// File: rtl/arith_logic_unit.sv
module arith_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;
  localparam int         MSB    = WIDTH - 1;

  // op bit 2 puts the shared adder into subtract mode (sub and slt)
  logic             inv_b;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             ovf;
  logic             less;

  assign inv_b = op_i[2];
  assign b_eff = inv_b ? ~b_i : b_i;
  assign sum   = a_i + b_eff + {{(WIDTH-1){1'b0}}, inv_b};
  assign ovf   = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
  assign less  = sum[MSB] ^ ovf;

  always_comb begin
    unique case (op_i)
      OP_AND:  result_o = a_i & b_i;
      OP_OR:   result_o = a_i | b_i;
      OP_ADD:  result_o = sum;
      OP_SUB:  result_o = sum;
      OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, less};
      OP_NOR:  result_o = ~(a_i | b_i);
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
endmodule

module arith_logic_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o
);
  always_comb begin
    if (!$isunknown(op_i)) begin
      if (op_i == 4'b0000)
        p_and_subset_r1: assert (((result_o & ~a_i) == '0) && ((result_o & ~b_i) == '0));
      if (op_i == 4'b0001)
        p_or_cover_r2: assert (((a_i & ~result_o) == '0) && ((b_i & ~result_o) == '0));
      if (op_i == 4'b0010)
        p_add_wrap_r3: assert (WIDTH'(result_o - b_i) == a_i);
      if (op_i == 4'b0110)
        p_sub_wrap_r4: assert (WIDTH'(result_o + b_i) == a_i);
      if (op_i == 4'b0111)
        p_slt_signed_r5: assert ((result_o[WIDTH-1:1] == '0) &&
                                 (result_o[0] == ($signed(a_i) < $signed(b_i))));
      if (op_i == 4'b1100)
        p_nor_disjoint_r6: assert (((result_o & a_i) == '0) && ((result_o & b_i) == '0));
      if (op_i == 4'b0110)
        p_eq_zero_r7: assert (zero_o == (a_i == b_i));
      if (!(op_i inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100}))
        p_undef_op_r8: assert ((result_o == '0) && zero_o);
    end
  end
endmodule

bind arith_logic_unit arith_logic_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_arith_logic_unit.sv
module tb_arith_logic_unit;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zf;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  arith_logic_unit dut (.a_i(a), .b_i(b), .op_i(op), .result_o(res), .zero_o(zf));

  function automatic logic [31:0] model(logic [3:0] o, logic [31:0] x, logic [31:0] y);
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return {31'b0, $signed(x) < $signed(y)};
      4'b1100: return ~(x | y);
      default: return 32'h0;
    endcase
  endfunction

  task automatic drive_check(string tag, logic [3:0] o, logic [31:0] x, logic [31:0] y);
    logic [31:0] exp;
    @(posedge clk);
    op = o; a = x; b = y;
    #10;
    exp = model(o, x, y);
    n_run++;
    if (res !== exp || zf !== (exp == 32'h0)) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h: got res=%h zero=%b, want res=%h zero=%b",
               tag, o, x, y, res, zf, exp, exp == 32'h0);
    end
  endtask

  task automatic t_start();
    drive_check("R1 start all-zero AND", 4'b0000, 32'h0, 32'h0);
  endtask

  task automatic t_logic();
    drive_check("R1 AND", 4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00);
    drive_check("R1 AND disjoint", 4'b0000, 32'hAAAA_AAAA, 32'h5555_5555);
    drive_check("R2 OR", 4'b0001, 32'hF000_0001, 32'h0000_1F00);
    drive_check("R2 OR zeros", 4'b0001, 32'h0, 32'h0);
    drive_check("R6 NOR", 4'b1100, 32'h1234_5678, 32'h0F0F_0000);
    drive_check("R6 NOR all ones", 4'b1100, 32'hFFFF_0000, 32'h0000_FFFF);
  endtask

  task automatic t_arith();
    drive_check("R3 ADD", 4'b0010, 32'd100, 32'd23);
    drive_check("R3 ADD wrap", 4'b0010, 32'hFFFF_FFFF, 32'h1);
    drive_check("R3 ADD signed ovf", 4'b0010, 32'h7FFF_FFFF, 32'h1);
    drive_check("R4 SUB", 4'b0110, 32'd50, 32'd8);
    drive_check("R4 SUB borrow", 4'b0110, 32'h0, 32'h1);
    drive_check("R4 SUB signed ovf", 4'b0110, 32'h8000_0000, 32'h1);
  endtask

  task automatic t_slt();
    drive_check("R5 SLT neg<pos", 4'b0111, 32'hFFFF_FFFF, 32'h1);
    drive_check("R5 SLT pos>neg", 4'b0111, 32'h1, 32'hFFFF_FFFF);
    drive_check("R5 SLT min<max", 4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
    drive_check("R5 SLT max>min", 4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
    drive_check("R5 SLT equal", 4'b0111, 32'h1234_0000, 32'h1234_0000);
    drive_check("R5 SLT small<large", 4'b0111, 32'd3, 32'd9);
  endtask

  task automatic t_zero();
    drive_check("R7 SUB equal", 4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    drive_check("R7 SUB unequal", 4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
    drive_check("R7 ADD to zero", 4'b0010, 32'h8000_0000, 32'h8000_0000);
    drive_check("R7 NOR zero", 4'b1100, 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic t_undef();
    for (int k = 0; k < 16; k++) begin
      if (!(k inside {0, 1, 2, 6, 7, 12}))
        drive_check("R8 undefined code", 4'(k), 32'hFFFF_FFFF, 32'h1357_9BDF);
    end
  endtask

  task automatic t_random();
    logic [3:0] ops [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    for (int i = 0; i < 300; i++)
      drive_check("R1-R6 random", ops[i % 6], $urandom, (i % 7 == 0) ? 32'h0 : $urandom);
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    t_start();
    t_logic();
    t_arith();
    t_slt();
    t_zero();
    t_undef();
    t_random();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule